// File: doc/BRIEF.md
# Frame-Synchronous Video Path Selector

This block routes one of several streaming pixel sources to a single downstream consumer. The sources are an auxiliary path and two bypass paths. A build parameter adds a fourth, secondary input path. Every source stream carries:

- a pixel word,
- a valid strobe,
- a new-frame marker that comes with the first pixel of a frame,
- an end-of-frame marker that comes with the last pixel.

The selected stream passes through one register stage. Its frame markers are re-issued from that stage, so the next stage can derive its own.

Software writes a pending (shadow) selection code at any time. The code becomes the active selection only when a frame starts on the relevant stream, so a running frame is never cut by a register write. After reset the active selection is "disabled". In that state nothing reaches the output and all input streams are consumed and dropped. Both the pending code and the active code can be read back at all times.

Top module: `vid_path_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pending code and the active code both read 0, and out_valid, out_nf and out_eof are low.
- R2: A write with cfg_wr_en high sets cfg_pending to cfg_wr_sel on the next clock. The codes are 0 = disabled, 1 = auxiliary (bit 0 of the source buses), 2 = bypass 0 (bit 1), 3 = bypass 1 (bit 2) and 4 = secondary (bit 3, present only when HAS_SEC = 1). cfg_active does not follow a write until a frame start commits it.
- R3: A pending code that names a source is committed when that source presents valid together with new-frame. The commit happens in that same cycle. The following clock shows the source's first pixel with out_valid and out_nf high, and cfg_active equal to the code.
- R4: Data, valid and end-of-frame of the active source appear at the outputs exactly one clock later. out_eof is high together with the last pixel.
- R5: While the effective selection is 0, or any code that names no present source (5 to 7, and 4 without the secondary path), the next clock shows out_valid, out_nf, out_eof and out_data all zero, whatever the inputs do.
- R6: If the pending code is written several times before the commit, only the last value is committed.
- R7: Valid, data and new-frame markers on sources that are neither active nor pending-and-starting do not reach the outputs and do not commit a selection.
- R8: A pending code that names no source is committed on the next valid new-frame of the currently active source. If no source is active, nothing is committed.
- R9: A write in the same cycle as a committing new-frame does not affect that commit. The previously pending value is committed, and the written value stays pending for the next frame start.
- R10: A new-frame or end-of-frame marker with its valid low is ignored. It neither commits a selection nor raises an output marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the pending selection code |
| cfg_wr_sel | input | 3 | Selection code to write |
| cfg_pending | output | 3 | Read-back of the pending (shadow) code |
| cfg_active | output | 3 | Read-back of the active code |
| src_data | input | NSRC*DATA_W | Pixel words; source k in bits [k*DATA_W +: DATA_W] |
| src_valid | input | NSRC | Valid strobe, one per source |
| src_nf | input | NSRC | New-frame marker, one per source |
| src_eof | input | NSRC | End-of-frame marker, one per source |
| out_data | output | DATA_W | Forwarded pixel word |
| out_valid | output | 1 | Forwarded valid |
| out_nf | output | 1 | Re-issued new-frame marker |
| out_eof | output | 1 | Re-issued end-of-frame marker |

## Verification
A wrong pending or active code shows up at the read-back ports on the next clock. If the active code is wrong, the first later pixel on either the wrong or the right source shows it one clock later, as an unexpected or missing out_valid. A commit on the wrong stream, or in the wrong cycle, moves the clock at which out_nf rises by at least one frame start. The bench therefore places new-frame pulses on competing sources in the same cycles as writes and commits. Loss of the disabled state shows up as any output activity while both codes are idle.

// File: rtl/vsel_pkg.sv
// Package: shared selection codes and helpers for the video path selector.
// Assumes: source k of the packed source buses maps to code k+1.
package vsel_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF = 3'd0,
        SEL_AUX = 3'd1,
        SEL_BP0 = 3'd2,
        SEL_BP1 = 3'd3,
        SEL_SEC = 3'd4
    } sel_code_e;

    // True when a code names a source that exists in a build with nsrc sources.
    function automatic logic code_names_src(input logic [SEL_W-1:0] code, input int nsrc);
        return (code != SEL_OFF) && (int'(code) <= nsrc);
    endfunction
endpackage

// File: rtl/vsel_cfg.sv
// Module: vsel_cfg
// Holds the pending (shadow) and active selection codes. Commits the pending
// code on the frame start that applies: the pending source's valid new-frame
// when the code names a source, otherwise the active source's valid new-frame.
// Assumes: src_fire[k] is already valid AND new-frame for source k.
module vsel_cfg
    import vsel_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NSRC-1:0]  src_fire,
    output logic [SEL_W-1:0] pending_q,
    output logic [SEL_W-1:0] active_q,
    output logic [SEL_W-1:0] eff_sel,
    output logic             commit
);
    logic pend_fire;
    logic act_fire;

    // Look up the frame-start pulse of the pending and the active source.
    always_comb begin
        pend_fire = 1'b0;
        act_fire  = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (pending_q == SEL_W'(k + 1)) pend_fire = src_fire[k];
            if (active_q  == SEL_W'(k + 1)) act_fire  = src_fire[k];
        end
    end

    // Decide the commit and the selection that steers this cycle's data.
    always_comb begin
        if (code_names_src(pending_q, NSRC)) commit = pend_fire;
        else                                 commit = act_fire;
        eff_sel = commit ? pending_q : active_q;
    end

    // Pending register: takes each software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending_q <= SEL_OFF;
        else if (wr_en) pending_q <= wr_sel;
    end

    // Active register: follows the pending code only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= SEL_OFF;
        else if (commit) active_q <= pending_q;
    end

    assert_shadow_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pending_q == $past(wr_sel));
    assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_q));
    assert_commit_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active_q == $past(pending_q));
    assert_commit_needs_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (src_fire != '0));
endmodule

// File: rtl/vsel_mux.sv
// Module: vsel_mux
// AND-OR selector: forwards the source named by sel. Markers and data are
// gated by that source's valid. A code naming no source forwards nothing.
// Assumes: sel is already the effective selection for this cycle.
module vsel_mux
    import vsel_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]       sel,
    input  logic [NSRC*DATA_W-1:0] src_data,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_nf,
    input  logic [NSRC-1:0]        src_eof,
    output logic [DATA_W-1:0]      pix_data,
    output logic                   pix_valid,
    output logic                   pix_nf,
    output logic                   pix_eof,
    output logic                   sel_ok
);
    logic [NSRC-1:0] hit;

    // One-hot decode of the selection code, one bit per source.
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_dec
            assign hit[g] = (sel == SEL_W'(g + 1));
        end
    endgenerate

    // Merge the selected, valid-qualified stream.
    always_comb begin
        pix_data  = '0;
        pix_valid = 1'b0;
        pix_nf    = 1'b0;
        pix_eof   = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (hit[k] && src_valid[k]) begin
                pix_data  = pix_data | src_data[k*DATA_W +: DATA_W];
                pix_valid = 1'b1;
                pix_nf    = src_nf[k];
                pix_eof   = src_eof[k];
            end
        end
        sel_ok = |hit;
    end
endmodule

// File: rtl/vsel_outreg.sv
// Module: vsel_outreg
// Single pipeline stage that re-issues the selected stream and its markers.
// Assumes: inputs come straight from the selector in the same cycle.
module vsel_outreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ok,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_nf,
    input  logic              in_eof,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_nf,
    output logic              out_eof
);
    // Register the stream; reset clears data and every marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_nf    <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_data  <= in_data;
            out_valid <= in_valid;
            out_nf    <= in_nf;
            out_eof   <= in_eof;
        end
    end

    assert_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid && out_data == $past(in_data));
    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> !out_valid && !out_nf && !out_eof && out_data == '0);
    assert_markers_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_nf || out_eof) |-> out_valid);
endmodule

// File: rtl/vid_path_sel.sv
// Module: vid_path_sel (top)
// Frame-synchronous path selector: the pending code is committed on a frame
// start, the chosen stream leaves through one register stage.
// Assumes: each source raises new-frame together with valid on its first pixel.
module vid_path_sel
    import vsel_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int HAS_SEC = 1,
    localparam int NSRC   = (HAS_SEC != 0) ? 4 : 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [SEL_W-1:0]       cfg_wr_sel,
    output logic [SEL_W-1:0]       cfg_pending,
    output logic [SEL_W-1:0]       cfg_active,
    input  logic [NSRC*DATA_W-1:0] src_data,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_nf,
    input  logic [NSRC-1:0]        src_eof,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_valid,
    output logic                   out_nf,
    output logic                   out_eof
);
    logic [NSRC-1:0]   fire;
    logic [SEL_W-1:0]  eff_sel;
    logic              commit;
    logic [DATA_W-1:0] pix_data;
    logic              pix_valid;
    logic              pix_nf;
    logic              pix_eof;
    logic              sel_ok;

    // Frame starts count only when they come with valid.
    assign fire = src_valid & src_nf;

    vsel_cfg #(.NSRC(NSRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .src_fire  (fire),
        .pending_q (cfg_pending),
        .active_q  (cfg_active),
        .eff_sel   (eff_sel),
        .commit    (commit)
    );

    vsel_mux #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mux (
        .sel       (eff_sel),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_nf    (src_nf),
        .src_eof   (src_eof),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_nf    (pix_nf),
        .pix_eof   (pix_eof),
        .sel_ok    (sel_ok)
    );

    vsel_outreg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ok    (sel_ok),
        .in_data   (pix_data),
        .in_valid  (pix_valid),
        .in_nf     (pix_nf),
        .in_eof    (pix_eof),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_nf    (out_nf),
        .out_eof   (out_eof)
    );

    assert_nf_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && code_names_src(cfg_pending, NSRC)) |=> out_nf && out_valid);
endmodule

// File: tb/vid_path_sel_tb.sv
// Bench: vector table walked by one loop, then directed reset checks.
module vid_path_sel_tb_top;
    localparam int DW = 16;
    localparam int NS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr_en = 1'b0;
    logic [2:0]      cfg_wr_sel = '0;
    logic [2:0]      cfg_pending;
    logic [2:0]      cfg_active;
    logic [NS*DW-1:0] src_data = '0;
    logic [NS-1:0]   src_valid = '0;
    logic [NS-1:0]   src_nf = '0;
    logic [NS-1:0]   src_eof = '0;
    logic [DW-1:0]   out_data;
    logic            out_valid;
    logic            out_nf;
    logic            out_eof;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    vid_path_sel #(.DATA_W(DW), .HAS_SEC(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_pending(cfg_pending), .cfg_active(cfg_active),
        .src_data(src_data), .src_valid(src_valid), .src_nf(src_nf), .src_eof(src_eof),
        .out_data(out_data), .out_valid(out_valid), .out_nf(out_nf), .out_eof(out_eof)
    );

    // Row: write, code, valid/nf/eof per source (bit0 aux .. bit3 sec),
    // expected valid/nf/eof, expected source code, pending, active, tag.
    typedef struct packed {
        logic       wr;
        logic [2:0] sel;
        logic [3:0] v;
        logic [3:0] nf;
        logic [3:0] eof;
        logic       ov;
        logic       onf;
        logic       oeof;
        logic [2:0] osrc;
        logic [2:0] opend;
        logic [2:0] oact;
        logic [3:0] req;
    } row_t;

    localparam int NROWS = 25;
    localparam row_t TBL [NROWS] = '{
        {1'b1,3'd1,4'b0001,4'b0001,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd1,3'd0,4'd5},  // R5 off drops aux
        {1'b0,3'd0,4'b0001,4'b0001,4'b0000,1'b1,1'b1,1'b0,3'd1,3'd1,3'd1,4'd3},  // R3 commit aux
        {1'b0,3'd0,4'b0011,4'b0010,4'b0000,1'b1,1'b0,1'b0,3'd1,3'd1,3'd1,4'd7},  // R7 bp0 ignored
        {1'b1,3'd2,4'b0001,4'b0000,4'b0001,1'b1,1'b0,1'b1,3'd1,3'd2,3'd1,4'd4},  // R4 eof
        {1'b0,3'd0,4'b0011,4'b0001,4'b0000,1'b1,1'b1,1'b0,3'd1,3'd2,3'd1,4'd2},  // R2 no commit
        {1'b1,3'd3,4'b0010,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd3,3'd1,4'd6},  // R6
        {1'b1,3'd4,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd4,3'd1,4'd6},  // R6
        {1'b0,3'd0,4'b0110,4'b0110,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd4,3'd1,4'd7},  // R7
        {1'b0,3'd0,4'b1001,4'b1000,4'b0000,1'b1,1'b1,1'b0,3'd4,3'd4,3'd4,4'd6},  // R6 last wins
        {1'b0,3'd0,4'b1000,4'b0000,4'b1000,1'b1,1'b0,1'b1,3'd4,3'd4,3'd4,4'd4},  // R4
        {1'b1,3'd0,4'b1000,4'b0000,4'b0000,1'b1,1'b0,1'b0,3'd4,3'd0,3'd4,4'd8},  // R8 pending off
        {1'b0,3'd0,4'b1001,4'b1001,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd0,3'd0,4'd8},  // R8 committed
        {1'b0,3'd0,4'b1001,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd0,3'd0,4'd5},  // R5
        {1'b1,3'd6,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd6,3'd0,4'd2},  // R2
        {1'b0,3'd0,4'b0001,4'b0001,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd6,3'd0,4'd8},  // R8 none active
        {1'b1,3'd2,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd2,3'd0,4'd2},  // R2
        {1'b1,3'd3,4'b0010,4'b0010,4'b0000,1'b1,1'b1,1'b0,3'd2,3'd3,3'd2,4'd9},  // R9
        {1'b0,3'd0,4'b0110,4'b0100,4'b0010,1'b1,1'b1,1'b0,3'd3,3'd3,3'd3,4'd3},  // R3 bp1
        {1'b0,3'd0,4'b0100,4'b0000,4'b0100,1'b1,1'b0,1'b1,3'd3,3'd3,3'd3,4'd4},  // R4
        {1'b1,3'd5,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd5,3'd3,4'd2},  // R2
        {1'b0,3'd0,4'b0100,4'b0100,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd5,3'd5,4'd5},  // R5 code 5
        {1'b0,3'd0,4'b0100,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd5,3'd5,4'd5},  // R5
        {1'b1,3'd2,4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0,3'd0,3'd2,3'd5,4'd2},  // R2
        {1'b0,3'd0,4'b0000,4'b0010,4'b0010,1'b0,1'b0,1'b0,3'd0,3'd2,3'd5,4'd10}, // R10
        {1'b0,3'd0,4'b0010,4'b0010,4'b0000,1'b1,1'b1,1'b0,3'd2,3'd2,3'd2,4'd3}   // R3
    };

    // Compare packed actual against expected; report FAIL with the tag.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_obs();
        return {3'd0, out_valid, out_nf, out_eof, cfg_pending, cfg_active, out_data};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", pack_obs(), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after reset", pack_obs(), 32'd0);

        for (int i = 0; i < NROWS; i++) begin
            row_t r;
            logic [DW-1:0] ed;
            r = TBL[i];
            @(negedge clk);
            cfg_wr_en  = r.wr;
            cfg_wr_sel = r.sel;
            src_valid  = r.v;
            src_nf     = r.nf;
            src_eof    = r.eof;
            for (int k = 0; k < NS; k++)
                src_data[k*DW +: DW] = DW'(((k + 1) << 12) | i);
            @(posedge clk); #2;
            ed = r.ov ? DW'((int'(r.osrc) << 12) | i) : '0;
            check($sformatf("R%0d row %0d", r.req, i), pack_obs(),
                  {3'd0, r.ov, r.onf, r.oeof, r.opend, r.oact, ed});
        end

        // R1: reset mid-stream clears both codes and the outputs
        @(negedge clk);
        cfg_wr_en = 1'b0;
        rst_n = 1'b0;
        src_valid = 4'b0010; src_nf = 4'b0010; src_eof = '0;
        @(posedge clk); #2;
        check("R1 mid-run reset", pack_obs(), 32'd0);
        // R5: disabled again after reset, bp0 frame start is dropped
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        check("R5 off after reset", pack_obs(), 32'd0);

        @(negedge clk);
        src_valid = '0; src_nf = '0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule